// File: doc/BRIEF.md
# Interlocked Two-Wire Byte Link

This block moves 9-bit frames between two peers over a pair of open-drain wires, one carrying the data value and one used for attention and acknowledge. There is no shared clock. Every bit is passed with a full interlock. The sender presents the bit level and pulses the attention wire low. The receiver answers by holding attention low and taking the bit. The sender then flips the data wire so the receiver can see that the bit was consumed. The receiver lets go of attention, and the sender releases data before it starts the next bit.

A frame starts with a kind flag, where 1 marks a command and 0 marks plain data. The eight payload bits follow, most significant first. The local side sends a frame by pulsing a request together with the flag and byte. A received frame comes back as a one-cycle valid strobe beside the flag and byte. Both wires are modelled as drive-low enables with external pull-ups, and the line inputs are synchronised before any decision is taken on them. A per-frame watchdog counts cycles while a frame is in flight. If the frame stalls, the watchdog drops both drives and returns the block to idle.

Top module: `bitlock_xcvr`

## Requirements
- R1: After reset the block is idle: `busy_o`, `send_done_o`, `recv_valid_o`, `abort_o` and both pull outputs are 0.
- R2: A frame carries the flag first and then byte bits 7 down to 0. The data wire is low for a 0 bit and released for a 1 bit at the moment attention first falls for that bit. The peer presents exactly the sent flag (`recv_cmd_o`) and byte (`recv_byte_o`) with `recv_valid_o` high for one cycle.
- R3: When a sent frame's final handshake completes, `send_done_o` pulses high for one cycle with `busy_o` already low.
- R4: A node never reports its own transmitted frame as received.
- R5: `send_req_i` is ignored while `busy_o` is high. This applies whether the node is sending or receiving.
- R6: If a frame is still in flight `TIMEOUT_CYCLES` clock edges after the edge that accepted it, `abort_o` is high for one cycle. On the next cycle `busy_o` and both pulls are 0, and no `send_done_o` is given.
- R7: A receive that stalls (attention held low with no data flip) is aborted the same way and yields no `recv_valid_o`.
- R8: After an abort, no new frame is started until the attention wire has been seen released. Normal frames work again afterwards.
- R9: Two nodes on the same wire pair can exchange frames in both directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| attn_line_i | input | 1 | Level seen on the attention wire |
| data_line_i | input | 1 | Level seen on the data wire |
| attn_pull_o | output | 1 | 1 pulls the attention wire low |
| data_pull_o | output | 1 | 1 pulls the data wire low |
| send_req_i | input | 1 | Request to send one frame (taken when idle) |
| send_cmd_i | input | 1 | Flag of the frame to send (1 = command) |
| send_byte_i | input | 8 | Payload to send |
| busy_o | output | 1 | A frame is being sent or received |
| send_done_o | output | 1 | One-cycle strobe: sent frame completed |
| recv_valid_o | output | 1 | One-cycle strobe: a frame was received |
| recv_cmd_o | output | 1 | Flag of the received frame |
| recv_byte_o | output | 8 | Payload of the received frame |
| abort_o | output | 1 | One-cycle strobe: watchdog abandoned the frame |

## Verification
The bench snoops the wires and rebuilds each frame from the data level at every attention fall. Because of this, a flipped bit order or a missing flag bit shows up even when both peers share the same mistake. A receiver that went back to listening without waiting for attention to rise would take its own stale low as a new bit, and frames would come out corrupted or doubled. The watchdog is timed to the exact edge, so an off-by-one limit or a counter that keeps running across frames is caught. While attention is still held low after an abort, the node is watched to confirm it stays idle. A design that re-arms at once would lock itself into a fresh stalled frame.

// File: rtl/bitlock_pkg.sv
package bitlock_pkg;

  // Sender sequencing: wait for quiet wire, present level, pulse attention,
  // gap and check for receiver hold, then wait for the acknowledge release.
  typedef enum logic [2:0] {
    TX_IDLE,
    TX_WAIT_HI,
    TX_SETUP,
    TX_PULSE,
    TX_GAP,
    TX_ACKWAIT
  } tx_state_e;

  // Receiver sequencing per bit.
  typedef enum logic [1:0] {
    RX_IDLE,
    RX_WAIT_LOW,
    RX_WAIT_FLIP,
    RX_WAIT_HI
  } rx_state_e;

  // Shortest settle count that covers the synchroniser plus one decision flop.
  localparam int MIN_SETTLE = 3;

endpackage

// File: rtl/bitlock_sync.sv
module bitlock_sync #(
  parameter int              WIDTH     = 2,
  parameter int              STAGES    = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  localparam int DEPTH = (STAGES < 2) ? 2 : STAGES;

  logic [DEPTH-1:0][WIDTH-1:0] stage_q;
  logic [DEPTH-1:0][WIDTH-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[DEPTH-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= {DEPTH{RESET_VAL}};
    end else begin
      stage_q <= stage_d;
    end
  end

  assign q_o = stage_q[DEPTH-1];

endmodule

// File: rtl/bitlock_wdog.sv
module bitlock_wdog #(
  parameter int LIMIT = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  output logic expire_o
);

  localparam int                LIM   = (LIMIT < 2) ? 2 : LIMIT;
  localparam int                CNT_W = $clog2(LIM + 1);
  localparam logic [CNT_W-1:0]  LAST  = CNT_W'(LIM - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             expire;

  assign expire = active_i && (cnt_q == LAST);

  always_comb begin
    if (active_i && !expire) begin
      cnt_d = cnt_q + CNT_W'(1);
    end else begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign expire_o = expire;

endmodule

// File: rtl/bitlock_tx.sv
module bitlock_tx
  import bitlock_pkg::*;
#(
  parameter int BYTE_W        = 8,
  parameter int SETTLE_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              flag_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              attn_s_i,
  input  logic              abort_i,
  output logic              attn_pull_o,
  output logic              data_pull_o,
  output logic              active_o,
  output logic              done_o
);

  localparam int               FRAME_BITS = BYTE_W + 1;
  localparam int               SETTLE_EFF = (SETTLE_CYCLES < MIN_SETTLE) ? MIN_SETTLE : SETTLE_CYCLES;
  localparam int               SET_W      = $clog2(SETTLE_EFF + 1);
  localparam int               CNT_W      = $clog2(FRAME_BITS + 1);
  localparam logic [SET_W-1:0] SET_LAST   = SET_W'(SETTLE_EFF - 1);
  localparam logic [CNT_W-1:0] BIT_LAST   = CNT_W'(FRAME_BITS - 1);

  tx_state_e             state_q, state_d;
  logic [FRAME_BITS-1:0] shift_q, shift_d;
  logic [CNT_W-1:0]      bits_q, bits_d;
  logic [SET_W-1:0]      settle_q, settle_d;
  logic                  attn_q, attn_d;
  logic                  data_q, data_d;
  logic                  done_q, done_d;

  always_comb begin
    state_d  = state_q;
    shift_d  = shift_q;
    bits_d   = bits_q;
    settle_d = settle_q;
    attn_d   = attn_q;
    data_d   = data_q;
    done_d   = 1'b0;

    case (state_q)
      TX_IDLE: begin
        if (start_i) begin
          shift_d = {flag_i, byte_i};
          bits_d  = '0;
          state_d = TX_WAIT_HI;
        end
      end
      TX_WAIT_HI: begin
        // Present the level one cycle ahead of the attention pulse.
        if (attn_s_i) begin
          data_d  = ~shift_q[FRAME_BITS-1];
          state_d = TX_SETUP;
        end
      end
      TX_SETUP: begin
        attn_d   = 1'b1;
        settle_d = '0;
        state_d  = TX_PULSE;
      end
      TX_PULSE: begin
        if (settle_q == SET_LAST) begin
          attn_d   = 1'b0;
          settle_d = '0;
          state_d  = TX_GAP;
        end else begin
          settle_d = settle_q + SET_W'(1);
        end
      end
      TX_GAP: begin
        if (settle_q == SET_LAST) begin
          settle_d = '0;
          if (!attn_s_i) begin
            // Receiver holds the wire: flip data as the taken marker.
            data_d  = ~data_q;
            state_d = TX_ACKWAIT;
          end else begin
            attn_d  = 1'b1;
            state_d = TX_PULSE;
          end
        end else begin
          settle_d = settle_q + SET_W'(1);
        end
      end
      TX_ACKWAIT: begin
        if (attn_s_i) begin
          data_d  = 1'b0;
          shift_d = {shift_q[FRAME_BITS-2:0], 1'b0};
          bits_d  = bits_q + CNT_W'(1);
          if (bits_q == BIT_LAST) begin
            state_d = TX_IDLE;
            done_d  = 1'b1;
          end else begin
            state_d = TX_WAIT_HI;
          end
        end
      end
      default: begin
        state_d = TX_IDLE;
        attn_d  = 1'b0;
        data_d  = 1'b0;
      end
    endcase

    if (abort_i) begin
      state_d = TX_IDLE;
      attn_d  = 1'b0;
      data_d  = 1'b0;
      done_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= TX_IDLE;
      shift_q  <= '0;
      bits_q   <= '0;
      settle_q <= '0;
      attn_q   <= 1'b0;
      data_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      shift_q  <= shift_d;
      bits_q   <= bits_d;
      settle_q <= settle_d;
      attn_q   <= attn_d;
      data_q   <= data_d;
      done_q   <= done_d;
    end
  end

  assign attn_pull_o = attn_q;
  assign data_pull_o = data_q;
  assign active_o    = (state_q != TX_IDLE);
  assign done_o      = done_q;

endmodule

// File: rtl/bitlock_rx.sv
module bitlock_rx
  import bitlock_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable_i,
  input  logic              attn_s_i,
  input  logic              data_s_i,
  input  logic              abort_i,
  output logic              attn_pull_o,
  output logic              valid_o,
  output logic              flag_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              active_o
);

  localparam int               FRAME_BITS = BYTE_W + 1;
  localparam int               CNT_W      = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] BIT_ALL    = CNT_W'(FRAME_BITS);

  rx_state_e             state_q, state_d;
  logic [FRAME_BITS-1:0] shift_q, shift_d;
  logic [CNT_W-1:0]      bits_q, bits_d;
  logic                  sampled_q, sampled_d;
  logic                  attn_q, attn_d;
  logic                  valid_q, valid_d;
  logic                  armed_q, armed_d;

  always_comb begin
    state_d   = state_q;
    shift_d   = shift_q;
    bits_d    = bits_q;
    sampled_d = sampled_q;
    attn_d    = attn_q;
    valid_d   = 1'b0;
    armed_d   = attn_s_i ? 1'b1 : armed_q;

    case (state_q)
      RX_IDLE: begin
        bits_d = '0;
        if (enable_i && armed_q && !attn_s_i) begin
          attn_d    = 1'b1;
          sampled_d = data_s_i;
          shift_d   = {shift_q[FRAME_BITS-2:0], data_s_i};
          state_d   = RX_WAIT_FLIP;
        end
      end
      RX_WAIT_LOW: begin
        if (!attn_s_i) begin
          attn_d    = 1'b1;
          sampled_d = data_s_i;
          shift_d   = {shift_q[FRAME_BITS-2:0], data_s_i};
          state_d   = RX_WAIT_FLIP;
        end
      end
      RX_WAIT_FLIP: begin
        if (data_s_i != sampled_q) begin
          attn_d  = 1'b0;
          bits_d  = bits_q + CNT_W'(1);
          state_d = RX_WAIT_HI;
        end
      end
      RX_WAIT_HI: begin
        // Let the own released low drain out of the synchroniser first.
        if (attn_s_i) begin
          if (bits_q == BIT_ALL) begin
            valid_d = 1'b1;
            state_d = RX_IDLE;
          end else begin
            state_d = RX_WAIT_LOW;
          end
        end
      end
      default: begin
        state_d = RX_IDLE;
        attn_d  = 1'b0;
      end
    endcase

    if (abort_i) begin
      state_d = RX_IDLE;
      attn_d  = 1'b0;
      valid_d = 1'b0;
      armed_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= RX_IDLE;
      shift_q   <= '0;
      bits_q    <= '0;
      sampled_q <= 1'b0;
      attn_q    <= 1'b0;
      valid_q   <= 1'b0;
      armed_q   <= 1'b0;
    end else begin
      state_q   <= state_d;
      shift_q   <= shift_d;
      bits_q    <= bits_d;
      sampled_q <= sampled_d;
      attn_q    <= attn_d;
      valid_q   <= valid_d;
      armed_q   <= armed_d;
    end
  end

  assign attn_pull_o = attn_q;
  assign valid_o     = valid_q;
  assign flag_o      = shift_q[FRAME_BITS-1];
  assign byte_o      = shift_q[BYTE_W-1:0];
  assign active_o    = (state_q != RX_IDLE);

endmodule

// File: rtl/bitlock_xcvr.sv
module bitlock_xcvr #(
  parameter int BYTE_W         = 8,
  parameter int SYNC_STAGES    = 2,
  parameter int SETTLE_CYCLES  = 4,
  parameter int TIMEOUT_CYCLES = 100000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              attn_line_i,
  input  logic              data_line_i,
  output logic              attn_pull_o,
  output logic              data_pull_o,
  input  logic              send_req_i,
  input  logic              send_cmd_i,
  input  logic [BYTE_W-1:0] send_byte_i,
  output logic              busy_o,
  output logic              send_done_o,
  output logic              recv_valid_o,
  output logic              recv_cmd_o,
  output logic [BYTE_W-1:0] recv_byte_o,
  output logic              abort_o
);

  // Reset: asserted at once, released on a clock edge.
  logic [1:0] rst_pipe_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end

  assign rst_core_n = rst_pipe_q[1];

  logic attn_s, data_s;

  bitlock_sync #(
    .WIDTH     (2),
    .STAGES    (SYNC_STAGES),
    .RESET_VAL (2'b11)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .d_i   ({attn_line_i, data_line_i}),
    .q_o   ({attn_s, data_s})
  );

  logic tx_active, rx_active, tx_attn, rx_attn, tx_data, expire, tx_start;

  // A send is taken only with both engines idle and the wire quiet;
  // a falling attention the same cycle belongs to the receiver.
  assign tx_start = send_req_i && !tx_active && !rx_active && attn_s;

  bitlock_tx #(
    .BYTE_W        (BYTE_W),
    .SETTLE_CYCLES (SETTLE_CYCLES)
  ) u_tx (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .start_i     (tx_start),
    .flag_i      (send_cmd_i),
    .byte_i      (send_byte_i),
    .attn_s_i    (attn_s),
    .abort_i     (expire),
    .attn_pull_o (tx_attn),
    .data_pull_o (tx_data),
    .active_o    (tx_active),
    .done_o      (send_done_o)
  );

  bitlock_rx #(
    .BYTE_W (BYTE_W)
  ) u_rx (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .enable_i    (!tx_active),
    .attn_s_i    (attn_s),
    .data_s_i    (data_s),
    .abort_i     (expire),
    .attn_pull_o (rx_attn),
    .valid_o     (recv_valid_o),
    .flag_o      (recv_cmd_o),
    .byte_o      (recv_byte_o),
    .active_o    (rx_active)
  );

  bitlock_wdog #(
    .LIMIT (TIMEOUT_CYCLES)
  ) u_wdog (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .active_i (tx_active || rx_active),
    .expire_o (expire)
  );

  assign attn_pull_o = tx_attn || rx_attn;
  assign data_pull_o = tx_data;
  assign busy_o      = tx_active || rx_active;
  assign abort_o     = expire;

endmodule

// File: rtl/bitlock_xcvr_chk.sv
module bitlock_xcvr_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              attn_pull_o,
  input logic              data_pull_o,
  input logic              busy_o,
  input logic              send_done_o,
  input logic              recv_valid_o,
  input logic              recv_cmd_o,
  input logic [BYTE_W-1:0] recv_byte_o,
  input logic              abort_o
);

  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!attn_pull_o && !data_pull_o));

  // R2
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recv_valid_o |=> !recv_valid_o);

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    send_done_o |=> !send_done_o);

  // R3
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    send_done_o |-> !busy_o);

  // R4
  no_self_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(send_done_o && recv_valid_o));

  // R6
  abort_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> busy_o);

  // R6
  abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |=> (!busy_o && !attn_pull_o && !data_pull_o && !send_done_o));

  // R7
  abort_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |=> !recv_valid_o);

  logic unused_ok;
  assign unused_ok = ^{recv_cmd_o, recv_byte_o};

endmodule

bind bitlock_xcvr bitlock_xcvr_chk #(.BYTE_W(BYTE_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .attn_pull_o  (attn_pull_o),
  .data_pull_o  (data_pull_o),
  .busy_o       (busy_o),
  .send_done_o  (send_done_o),
  .recv_valid_o (recv_valid_o),
  .recv_cmd_o   (recv_cmd_o),
  .recv_byte_o  (recv_byte_o),
  .abort_o      (abort_o)
);

// File: tb/bitlock_xcvr_tb_top.sv
`timescale 1ns/1ps
module bitlock_xcvr_tb_top;

  localparam int TMO = 3000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n;
  logic a_req, a_cmd, b_req, b_cmd;
  logic [7:0] a_byte, b_byte;
  logic b_deaf, tb_attn_low;

  logic a_attn_pull, a_data_pull, a_busy, a_done, a_valid, a_rcmd, a_abort;
  logic b_attn_pull, b_data_pull, b_busy, b_done, b_valid, b_rcmd, b_abort;
  logic [7:0] a_rbyte, b_rbyte;
  logic attn_line, data_line, b_attn_in, b_data_in;

  assign attn_line = ~(a_attn_pull | b_attn_pull | tb_attn_low);
  assign data_line = ~(a_data_pull | b_data_pull);
  assign b_attn_in = attn_line | b_deaf;
  assign b_data_in = data_line | b_deaf;

  bitlock_xcvr #(.SETTLE_CYCLES(4), .TIMEOUT_CYCLES(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .attn_line_i(attn_line), .data_line_i(data_line),
    .attn_pull_o(a_attn_pull), .data_pull_o(a_data_pull),
    .send_req_i(a_req), .send_cmd_i(a_cmd), .send_byte_i(a_byte),
    .busy_o(a_busy), .send_done_o(a_done), .recv_valid_o(a_valid),
    .recv_cmd_o(a_rcmd), .recv_byte_o(a_rbyte), .abort_o(a_abort));

  bitlock_xcvr #(.SETTLE_CYCLES(4), .TIMEOUT_CYCLES(TMO)) peer_i (
    .clk(clk), .rst_n(rst_n), .attn_line_i(b_attn_in), .data_line_i(b_data_in),
    .attn_pull_o(b_attn_pull), .data_pull_o(b_data_pull),
    .send_req_i(b_req), .send_cmd_i(b_cmd), .send_byte_i(b_byte),
    .busy_o(b_busy), .send_done_o(b_done), .recv_valid_o(b_valid),
    .recv_cmd_o(b_rcmd), .recv_byte_o(b_rbyte), .abort_o(b_abort));

  int n_checks = 0;
  int n_err = 0;
  int a_vcnt = 0, b_vcnt = 0, a_dcnt = 0, b_dcnt = 0;
  logic [8:0] a_got, b_got, snoop;
  int snoop_n = 0;
  logic prev_attn = 1'b1;

  // Wire snooper and strobe counters.
  always @(negedge clk) begin
    if (a_valid) begin a_vcnt++; a_got = {a_rcmd, a_rbyte}; end
    if (b_valid) begin b_vcnt++; b_got = {b_rcmd, b_rbyte}; end
    if (a_done) a_dcnt++;
    if (b_done) b_dcnt++;
    if (prev_attn && !attn_line) begin
      snoop = {snoop[7:0], data_line};
      snoop_n++;
    end
    prev_attn = attn_line;
  end

  function automatic logic [8:0] frame_of(input logic cmd, input logic [7:0] val);
    return {cmd, val};
  endfunction

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_idle();
    for (int g = 0; g < 5000 && (a_busy || b_busy); g++) tick();
  endtask

  task automatic do_frame(input bit from_a, input logic cmd, input logic [7:0] val,
                          input string req);
    logic [8:0] exp;
    int sv, dv, sd;
    exp = frame_of(cmd, val);
    wait_idle();
    sv = from_a ? a_vcnt : b_vcnt;
    dv = from_a ? b_vcnt : a_vcnt;
    sd = from_a ? a_dcnt : b_dcnt;
    snoop_n = 0;
    if (from_a) begin a_cmd = cmd; a_byte = val; a_req = 1'b1; end
    else        begin b_cmd = cmd; b_byte = val; b_req = 1'b1; end
    tick();
    a_req = 1'b0; b_req = 1'b0;
    for (int g = 0; g < 3000 && ((from_a ? b_vcnt : a_vcnt) == dv); g++) tick();
    repeat (6) tick();
    if (from_a) begin
      check(b_vcnt == dv + 1, req, "frames received", b_vcnt - dv, 1);
      check(b_got == exp, req, "received frame", b_got, exp);
      check(a_vcnt == sv, "R4", "self echo count", a_vcnt - sv, 0);
      check(a_dcnt == sd + 1 && !a_busy, "R3", "done strobes", a_dcnt - sd, 1);
    end else begin
      check(a_vcnt == dv + 1, req, "frames received", a_vcnt - dv, 1);
      check(a_got == exp, req, "received frame", a_got, exp);
      check(b_vcnt == sv, "R4", "self echo count", b_vcnt - sv, 0);
      check(b_dcnt == sd + 1 && !b_busy, "R3", "done strobes", b_dcnt - sd, 1);
    end
    // R2: wire order, flag first then MSB..LSB
    check(snoop_n == 9 && snoop == exp, "R2", "wire bit sequence", snoop, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog run did not finish");
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

  initial begin
    int n, av, bv, ad, busy_seen;
    void'($urandom(32'h5eed));
    rst_n = 1'b0; a_req = 0; b_req = 0; a_cmd = 0; b_cmd = 0;
    a_byte = '0; b_byte = '0; b_deaf = 0; tb_attn_low = 0;
    repeat (5) tick();
    rst_n = 1'b1;
    repeat (6) tick();

    // R1 reset state
    check(!a_busy && !b_busy, "R1", "busy after reset", a_busy, 0);
    check(!a_attn_pull && !a_data_pull && !b_attn_pull && !b_data_pull, "R1",
          "pulls after reset", {a_attn_pull, a_data_pull, b_attn_pull, b_data_pull}, 0);
    check(!a_valid && !a_done && !a_abort, "R1", "strobes after reset",
          {a_valid, a_done, a_abort}, 0);

    // Directed frames, both directions (R9)
    do_frame(1'b1, 1'b1, 8'hA5, "R2");
    do_frame(1'b1, 1'b0, 8'h00, "R2");
    do_frame(1'b1, 1'b0, 8'hFF, "R2");
    do_frame(1'b0, 1'b1, 8'h01, "R9");
    do_frame(1'b0, 1'b0, 8'h80, "R9");
    do_frame(1'b0, 1'b1, 8'h5A, "R9");

    // R5 requests while busy are ignored
    wait_idle();
    bv = b_vcnt; av = a_vcnt;
    a_cmd = 0; a_byte = 8'h3C; a_req = 1; tick(); a_req = 0;
    repeat (20) tick();
    check(a_busy && b_busy, "R5", "both busy mid frame", {a_busy, b_busy}, 3);
    a_byte = 8'hC3; a_req = 1; b_cmd = 1; b_byte = 8'h99; b_req = 1;
    tick(); a_req = 0; b_req = 0;
    for (int g = 0; g < 3000 && b_vcnt == bv; g++) tick();
    repeat (400) tick();
    check(b_vcnt == bv + 1, "R5", "peer frame count", b_vcnt - bv, 1);
    check(b_got == frame_of(1'b0, 8'h3C), "R5", "peer frame", b_got, 9'h03C);
    check(a_vcnt == av, "R5", "stray request sent", a_vcnt - av, 0);

    // Random traffic (R2, R9)
    for (int i = 0; i < 30; i++) begin
      do_frame(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
               8'($urandom), (i % 2 == 0) ? "R2" : "R9");
    end

    // R6 send stall: peer deaf, watchdog edge count
    wait_idle();
    b_deaf = 1; repeat (5) tick();
    ad = a_dcnt; bv = b_vcnt;
    a_cmd = 1; a_byte = 8'h77; a_req = 1;
    n = 0;
    for (int g = 0; g < TMO + 100; g++) begin
      @(posedge clk); n++;
      #1 a_req = 0;
      @(negedge clk); #1;
      if (a_abort) break;
    end
    check(n == TMO, "R6", "edges to abort", n, TMO);
    tick();
    check(!a_busy && !a_attn_pull && !a_data_pull, "R6", "released after abort",
          {a_busy, a_attn_pull, a_data_pull}, 0);
    check(a_dcnt == ad, "R6", "done on aborted frame", a_dcnt - ad, 0);

    // R7 receive stall: attention held low by the bench
    repeat (10) tick();
    av = a_vcnt;
    tb_attn_low = 1;
    n = 0;
    for (int g = 0; g < TMO + 100 && !a_abort; g++) begin tick(); n++; end
    check(a_abort == 1'b1 && n > TMO - 20, "R7", "receive stall aborted", n, TMO);
    busy_seen = 0;
    for (int g = 0; g < 60; g++) begin tick(); if (a_busy) busy_seen++; end
    // R8: no restart while attention still low
    check(busy_seen == 0, "R8", "restart before release", busy_seen, 0);
    check(a_vcnt == av, "R7", "valid from stalled frame", a_vcnt - av, 0);
    tb_attn_low = 0;
    repeat (10) tick();
    check(!a_busy, "R8", "idle after release", a_busy, 0);
    b_deaf = 0;
    repeat (5) tick();
    do_frame(1'b1, 1'b1, 8'hC6, "R8");
    do_frame(1'b0, 1'b0, 8'h39, "R8");

    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

endmodule